// File: doc/BRIEF.md
# Triangle Carrier Counter with Direction-Selected Compare

This block produces the triangular carrier used by a three-phase complementary motor PWM stage. A 16-bit counter rises one step per clock from a floor to a ceiling, turns, falls back to the floor, turns again, and repeats for as long as the run input is high. The floor is twice the dead time Td. The ceiling is the period value plus twice Td. Keeping the floor at 2·Td leaves room for dead-time insertion further down the chain.

Each value the counter shows is compared against several register sets. A shared per-phase set is compared in both directions. An up-phase set and a peak-detect value are compared only for values reached by counting up. A down-phase set and the floor value 2·Td are compared only for values reached by counting down. Every match is a single-cycle strobe.

When run is low, the counter holds 2·Td and points up, so the next start always begins the same way. Reset is asynchronous and active-low, and the block releases it in step with the clock.

Top module: `tri_carrier`

## Requirements
- R1: While run is low, one clock after it is seen low, count equals 2·Td, count_dn is 0, and every hit output is 0.
- R2: While running and counting up, count increases by exactly one per clock.
- R3: The ceiling value period+2·Td is shown for exactly one cycle, with count_dn already 1 in that cycle. After it, count decreases by one per clock.
- R4: On the way down, the floor 2·Td is shown for exactly one cycle, with count_dn already 0. After it, count rises again, and the cycle repeats indefinitely.
- R5: On the first clock at which run is seen high after a stop, count becomes 2·Td+1 and the direction is up.
- R6: hit_both bit i (phase i occupies bits 16·i+15 down to 16·i of cmp_both) is 1 exactly in the cycles where a running count equals that phase's value, in either direction.
- R7: hit_up bit i is 1 exactly when the count equals cmp_up phase i and that value was reached by an upward step. The ceiling counts as reached upward.
- R8: hit_dn bit i is 1 exactly when the count equals cmp_dn phase i and that value was reached by a downward step. The floor counts as reached downward.
- R9: hit_peak is 1 exactly when the count equals peak_val and the value was reached by an upward step.
- R10: hit_floor is 1 exactly when a downward step brings the count to 2·Td.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low loads the start value |
| dead_time | input | 16 | Dead time Td; the floor is 2·Td |
| period | input | 16 | Carrier half-period; the ceiling is period+2·Td |
| cmp_both | input | 48 | Per-phase compare values, both directions |
| cmp_up | input | 48 | Per-phase compare values, upward only |
| cmp_dn | input | 48 | Per-phase compare values, downward only |
| peak_val | input | 16 | Peak-detect compare value, upward only |
| count | output | 16 | Carrier count |
| count_dn | output | 1 | 1 while the counter is heading down |
| hit_both | output | 3 | Per-phase match strobes, both directions |
| hit_up | output | 3 | Per-phase match strobes, upward values |
| hit_dn | output | 3 | Per-phase match strobes, downward values |
| hit_peak | output | 1 | Peak-detect match strobe |
| hit_floor | output | 1 | Floor reached by a downward step |

## Verification
The assertions assume the following about the inputs:
- period is at least 1.
- period+2·Td fits in 16 bits, and 2·Td fits as well.
- dead_time and period change only while run is low.

The bench changes these inputs only during stopped intervals. It sweeps small Td and period values that stay far from the width limit, and never uses a zero period.

// File: rtl/tri_pkg.sv
package tri_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
  localparam int unsigned CW  = 16;
  localparam int unsigned NPH = 3;
endpackage

// File: rtl/tri_bounds.sv
module tri_bounds #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] dead_time,
  input  logic [W-1:0] period,
  output logic [W-1:0] floor_v,
  output logic [W-1:0] ceil_v
);
  always_comb begin
    floor_v = {dead_time[W-2:0], 1'b0};
    ceil_v  = period + floor_v;
  end
endmodule

// File: rtl/tri_counter.sv
module tri_counter
  import tri_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] floor_v,
  input  logic [W-1:0] ceil_v,
  output logic [W-1:0] cnt_o,
  output dir_e         dir_o,
  output logic         arr_dn_o,
  output logic         active_o
);
  logic [W-1:0] cnt_q, cnt_d;
  dir_e         dir_q, dir_d;
  logic         arr_dn_q, arr_dn_d;
  logic         act_q, act_d;
  logic         upd;
  logic [W-1:0] inc_v, dec_v;

  always_comb begin
    inc_v    = cnt_q + 1'b1;
    dec_v    = cnt_q - 1'b1;
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    arr_dn_d = arr_dn_q;
    act_d    = run;
    if (!run) begin
      cnt_d    = floor_v;
      dir_d    = DIR_UP;
      arr_dn_d = 1'b0;
    end else if (dir_q == DIR_UP) begin
      cnt_d    = inc_v;
      arr_dn_d = 1'b0;
      if (inc_v == ceil_v) dir_d = DIR_DN;
    end else begin
      cnt_d    = dec_v;
      arr_dn_d = 1'b1;
      if (dec_v == floor_v) dir_d = DIR_UP;
    end
  end

  assign upd = run | act_q | (dir_q == DIR_DN) | (cnt_q != floor_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_q    <= DIR_UP;
      arr_dn_q <= 1'b0;
      act_q    <= 1'b0;
    end else if (upd) begin
      cnt_q    <= cnt_d;
      dir_q    <= dir_d;
      arr_dn_q <= arr_dn_d;
      act_q    <= act_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_o    = dir_q;
  assign arr_dn_o = arr_dn_q;
  assign active_o = act_q;

  // R1: a stop loads the floor on the next edge
  a_r1_stop_load: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(floor_v) && dir_q == DIR_UP));
  // R2: upward steps are +1
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir_q == DIR_UP) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: downward steps are -1
  a_r3_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir_q == DIR_DN) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3: the turn to down happens only on the ceiling
  a_r3_turn_at_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_q == DIR_DN) |-> (cnt_q == ceil_v));
  // R4: the turn to up happens only on the floor
  a_r4_turn_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_q == DIR_DN) |-> (cnt_q == floor_v));
  // R4: a running count stays between floor and ceiling
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_q) |-> (cnt_q >= floor_v && cnt_q <= ceil_v));
endmodule

// File: rtl/tri_compare.sv
module tri_compare #(
  parameter int unsigned W   = 16,
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cnt,
  input  logic           arr_dn,
  input  logic           active,
  input  logic [W-1:0]   floor_v,
  input  logic [NPH*W-1:0] cmp_both,
  input  logic [NPH*W-1:0] cmp_up,
  input  logic [NPH*W-1:0] cmp_dn,
  input  logic [W-1:0]   peak_val,
  output logic [NPH-1:0] hit_both,
  output logic [NPH-1:0] hit_up,
  output logic [NPH-1:0] hit_dn,
  output logic           hit_peak,
  output logic           hit_floor
);
  logic up_ok, dn_ok;

  always_comb begin
    up_ok = active & ~arr_dn;
    dn_ok = active &  arr_dn;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    always_comb begin
      hit_both[i] = active & (cnt == cmp_both[i*W +: W]);
      hit_up[i]   = up_ok  & (cnt == cmp_up[i*W +: W]);
      hit_dn[i]   = dn_ok  & (cnt == cmp_dn[i*W +: W]);
    end
  end

  always_comb begin
    hit_peak  = up_ok & (cnt == peak_val);
    hit_floor = dn_ok & (cnt == floor_v);
  end

  // R7, R8: up-set and down-set strobes never fire together
  a_r8_sets_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((|hit_up || hit_peak) && (|hit_dn || hit_floor)));
  // R10: a floor strobe is followed by an upward value
  a_r10_floor_then_up: assert property (@(posedge clk) disable iff (!rst_n)
    hit_floor |=> (!arr_dn || !active));
endmodule

// File: rtl/tri_carrier.sv
module tri_carrier
  import tri_pkg::*;
#(
  parameter int unsigned W   = CW,
  parameter int unsigned NPH = tri_pkg::NPH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [W-1:0]     dead_time,
  input  logic [W-1:0]     period,
  input  logic [NPH*W-1:0] cmp_both,
  input  logic [NPH*W-1:0] cmp_up,
  input  logic [NPH*W-1:0] cmp_dn,
  input  logic [W-1:0]     peak_val,
  output logic [W-1:0]     count,
  output logic             count_dn,
  output logic [NPH-1:0]   hit_both,
  output logic [NPH-1:0]   hit_up,
  output logic [NPH-1:0]   hit_dn,
  output logic             hit_peak,
  output logic             hit_floor
);
  logic [1:0]   rst_sync_q;
  logic         rst_s_n;
  logic [W-1:0] floor_v, ceil_v, cnt;
  dir_e         dir;
  logic         arr_dn, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  tri_bounds #(.W(W)) u_bounds (
    .dead_time(dead_time), .period(period),
    .floor_v(floor_v), .ceil_v(ceil_v)
  );

  tri_counter #(.W(W)) u_counter (
    .clk(clk), .rst_n(rst_s_n), .run(run),
    .floor_v(floor_v), .ceil_v(ceil_v),
    .cnt_o(cnt), .dir_o(dir), .arr_dn_o(arr_dn), .active_o(active)
  );

  tri_compare #(.W(W), .NPH(NPH)) u_compare (
    .clk(clk), .rst_n(rst_s_n), .cnt(cnt), .arr_dn(arr_dn), .active(active),
    .floor_v(floor_v), .cmp_both(cmp_both), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
    .peak_val(peak_val), .hit_both(hit_both), .hit_up(hit_up), .hit_dn(hit_dn),
    .hit_peak(hit_peak), .hit_floor(hit_floor)
  );

  assign count    = cnt;
  assign count_dn = (dir == DIR_DN);

  // R1: nothing strobes in the first cycle after a stop
  a_r1_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_s_n)
    !run |=> (hit_both == '0 && hit_up == '0 && hit_dn == '0 && !hit_peak && !hit_floor));
endmodule

// File: tb/tri_carrier_tb.sv
module tri_carrier_tb;
  localparam int W = 16;
  localparam int NPH = 3;

  logic clk, rst_n, run;
  logic [W-1:0] dead_time, period, peak_val;
  logic [NPH*W-1:0] cmp_both, cmp_up, cmp_dn;
  logic [W-1:0] count;
  logic count_dn, hit_peak, hit_floor;
  logic [NPH-1:0] hit_both, hit_up, hit_dn;

  int total = 0;
  int bad = 0;

  tri_carrier u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .dead_time(dead_time), .period(period),
    .cmp_both(cmp_both), .cmp_up(cmp_up), .cmp_dn(cmp_dn), .peak_val(peak_val),
    .count(count), .count_dn(count_dn), .hit_both(hit_both), .hit_up(hit_up),
    .hit_dn(hit_dn), .hit_peak(hit_peak), .hit_floor(hit_floor)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ph(input logic [NPH*W-1:0] v, input int i);
    return int'(v[i*W +: W]);
  endfunction

  // Check the stopped state at the current negedge
  task automatic chk_stopped(input int f);
    chk("R1 count", int'(count), f);
    chk("R1 dir", int'(count_dn), 0);
    chk("R1 hits", int'({hit_both, hit_up, hit_dn, hit_peak, hit_floor}), 0);
  endtask

  // Check a running cycle k steps after start
  task automatic chk_run(input int f, input int p, input int k);
    int m, ec, edn, hb, hu, hd;
    bit up_arr;
    string tag;
    m = k % (2 * p);
    up_arr = (m >= 1) && (m <= p);
    ec = (m <= p) ? f + m : f + 2 * p - m;
    edn = (m >= p) ? 1 : 0;
    if (k == 1) tag = "R5 count";
    else if (m == p) tag = "R3 ceiling";
    else if (m == 0) tag = "R4 floor";
    else if (up_arr) tag = "R2 up";
    else tag = "R3 down";
    chk(tag, int'(count), ec);
    chk(m == 0 ? "R4 dir" : "R3 dir", int'(count_dn), edn);
    hb = 0; hu = 0; hd = 0;
    for (int i = 0; i < NPH; i++) begin
      if (ec == ph(cmp_both, i)) hb |= (1 << i);
      if (up_arr && ec == ph(cmp_up, i)) hu |= (1 << i);
      if (!up_arr && ec == ph(cmp_dn, i)) hd |= (1 << i);
    end
    chk("R6 hit_both", int'(hit_both), hb);
    chk("R7 hit_up", int'(hit_up), hu);
    chk("R8 hit_dn", int'(hit_dn), hd);
    chk("R9 hit_peak", int'(hit_peak), (up_arr && ec == int'(peak_val)) ? 1 : 0);
    chk("R10 hit_floor", int'(hit_floor), (!up_arr && ec == f) ? 1 : 0);
  endtask

  task automatic setup(input int td, input int p);
    int f;
    f = 2 * td;
    dead_time = W'(td);
    period = W'(p);
    cmp_both = {W'(f), W'(f + p), W'(f + 1)};
    cmp_up   = {W'(f + 1), W'(f), W'(f + p)};
    cmp_dn   = {W'(f + 1), W'(f + p), W'(f)};
    peak_val = W'(f + p);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tds[3];
    int ps[4];
    tds = '{0, 2, 5};
    ps = '{1, 2, 3, 7};
    rst_n = 1'b0;
    run = 1'b0;
    setup(0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_stopped(0);
    foreach (tds[a]) begin
      foreach (ps[b]) begin
        setup(tds[a], ps[b]);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_stopped(2 * tds[a]);
        run = 1'b1;
        for (int k = 1; k <= 4 * ps[b] + 3; k++) begin
          @(negedge clk);
          chk_run(2 * tds[a], ps[b], k);
        end
        // restart mid-carrier (R5)
        run = 1'b0;
        @(negedge clk);
        chk_stopped(2 * tds[a]);
        run = 1'b1;
        for (int k = 1; k <= 2 * ps[b] + 2; k++) begin
          @(negedge clk);
          chk_run(2 * tds[a], ps[b], k);
        end
        run = 1'b0;
        @(negedge clk);
        chk_stopped(2 * tds[a]);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule